// File: doc/BRIEF.md
# SIMD Thread-Group Slice Sequencer

This block sits between the instruction decoder and a row of SIMD functional units. The decoder hands it one instruction token for a whole thread group, together with a flag that tells whether the group holds fragment threads or vertex threads, and a mask that says which threads of the group are active. The row holds fewer functional units than the group holds threads, so the sequencer replays the same token over several consecutive clocks. In each clock it presents one slice of the group: the slice index plus the lane enables taken from the matching part of the mask.

A fragment group has 32 threads and is issued over 4 clocks. A vertex group has 16 threads and is issued over 2 clocks. With 8 functional units, each clock covers 8 threads. While a replay runs, the ready output is low. The sequencer takes a new token on the clock that follows the last slice. A slice whose threads are all inactive still takes its clock, with every lane disabled, so an instruction always takes a fixed number of cycles for its group type.

Top module: `warp_slice_seq`

## Requirements
- R1: After reset, `in_ready` is 1, `fu_valid` is 0, `fu_slice` is 0, `fu_last` is 0 and `fu_lane_en` is all zero.
- R2: When `in_valid` and `in_ready` are both 1 at a rising edge, the token is accepted. In the next cycle `fu_valid` is 1, `fu_slice` is 0 and `in_ready` is 0.
- R3: A token accepted with `in_group_vtx` = 0 (fragment group) is issued in 4 consecutive cycles, with `fu_slice` equal to 0, 1, 2 and 3 in turn.
- R4: A token accepted with `in_group_vtx` = 1 (vertex group) is issued in 2 consecutive cycles, with `fu_slice` equal to 0 and then 1.
- R5: In an issue cycle with slice s, bit i of `fu_lane_en` equals bit s*8+i of the mask captured at acceptance.
- R6: `fu_token` is the accepted token during every issue cycle of that token.
- R7: A slice whose 8 mask bits are all zero still takes its issue cycle, with `fu_valid` 1 and `fu_lane_en` 0.
- R8: `in_ready` stays 0 during a replay. A request presented during a replay has no effect on `fu_token`, `fu_slice` or `fu_lane_en`.
- R9: `fu_last` is 1 only in the final issue cycle of a token. In the following cycle `fu_valid` is 0 and `in_ready` is 1.
- R10: For a vertex group, mask bits 16 to 31 do not affect any output.
- R11: Changes on `in_mask`, `in_token` and `in_group_vtx` after acceptance do not affect the replay in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction token is offered |
| in_ready | output | 1 | The sequencer can accept a token this cycle |
| in_token | input | TOKW (16) | Decoded instruction token |
| in_group_vtx | input | 1 | 1 = vertex group (16 threads), 0 = fragment group (32 threads) |
| in_mask | input | GRP_MAX (32) | Thread-active mask, bit t for thread t |
| fu_valid | output | 1 | A slice is issued to the functional units |
| fu_token | output | TOKW (16) | Token being replayed |
| fu_slice | output | SW (2) | Index of the slice being issued |
| fu_lane_en | output | LANES (8) | Per-lane enables for this slice |
| fu_last | output | 1 | This is the final slice of the token |

## Verification
The hardest cases to reach are a request that is held on the input during a replay, and an input mask that changes after acceptance. Either one could corrupt a replay that is already running. The stimulus keeps `in_valid` high with a different token and an inverted mask on every replay cycle. It then checks that the replay carries on unchanged, and that the waiting request is taken exactly on the cycle after the last slice. All-zero slices are placed in the middle of a group and at its end, and vertex groups carry nonzero upper mask bits.

// File: rtl/warp_seq_pkg.sv
package warp_seq_pkg;
  typedef enum logic {
    GRP_FRAG = 1'b0,
    GRP_VTX  = 1'b1
  } grp_kind_e;
endpackage

// File: rtl/wss_slice_ctr.sv
module wss_slice_ctr #(
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [SW-1:0] start_last,
  output logic          busy,
  output logic [SW-1:0] slice,
  output logic          at_last
);
  logic [SW-1:0] last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      slice  <= '0;
      last_q <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      slice  <= '0;
      last_q <= start_last;
    end else if (busy) begin
      if (slice == last_q) begin
        busy  <= 1'b0;
        slice <= '0;
      end else begin
        slice <= slice + 1'b1;
      end
    end
  end

  assign at_last = busy && (slice == last_q);
endmodule

// File: rtl/wss_lane_gate.sv
module wss_lane_gate #(
  parameter int LANES = 8,
  parameter int MW    = 32,
  parameter int SW    = 2
) (
  input  logic             busy,
  input  logic [SW-1:0]    slice,
  input  logic [MW-1:0]    mask,
  output logic [LANES-1:0] lane_en
);
  function automatic logic [LANES-1:0] slice_bits(input logic [MW-1:0] m,
                                                  input logic [SW-1:0] s);
    logic [MW-1:0] shifted;
    shifted = m >> (int'(s) * LANES);
    return shifted[LANES-1:0];
  endfunction

  logic [LANES-1:0] picked;
  assign picked = slice_bits(mask, slice);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_en[i] = busy & picked[i];
  end
endmodule

// File: rtl/warp_slice_seq.sv
module warp_slice_seq
  import warp_seq_pkg::*;
#(
  parameter int LANES    = 8,
  parameter int GRP_FRAG_THREADS = 32,
  parameter int GRP_VTX_THREADS  = 16,
  parameter int TOKW     = 16,
  localparam int GRP_MAX = GRP_FRAG_THREADS,
  localparam int FRAG_SLICES = GRP_FRAG_THREADS / LANES,
  localparam int VTX_SLICES  = GRP_VTX_THREADS / LANES,
  localparam int SW      = (FRAG_SLICES > 1) ? $clog2(FRAG_SLICES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [TOKW-1:0]    in_token,
  input  logic               in_group_vtx,
  input  logic [GRP_MAX-1:0] in_mask,
  output logic               fu_valid,
  output logic [TOKW-1:0]    fu_token,
  output logic [SW-1:0]      fu_slice,
  output logic [LANES-1:0]   fu_lane_en,
  output logic               fu_last
);
  function automatic logic [SW-1:0] last_slice_of(input grp_kind_e k);
    return (k == GRP_VTX) ? SW'(VTX_SLICES - 1) : SW'(FRAG_SLICES - 1);
  endfunction

  function automatic logic [GRP_MAX-1:0] live_mask(input grp_kind_e k,
                                                   input logic [GRP_MAX-1:0] m);
    logic [GRP_MAX-1:0] keep;
    keep = (k == GRP_VTX) ? {{(GRP_MAX-GRP_VTX_THREADS){1'b0}}, {GRP_VTX_THREADS{1'b1}}}
                          : '1;
    return m & keep;
  endfunction

  grp_kind_e          kind_in;
  grp_kind_e          kind_q;
  logic               accept;
  logic               busy;
  logic [TOKW-1:0]    token_q;
  logic [GRP_MAX-1:0] mask_q;

  assign kind_in  = grp_kind_e'(in_group_vtx);
  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      token_q <= '0;
      mask_q  <= '0;
      kind_q  <= GRP_FRAG;
    end else if (accept) begin
      token_q <= in_token;
      mask_q  <= live_mask(kind_in, in_mask);
      kind_q  <= kind_in;
    end
  end

  wss_slice_ctr #(.SW(SW)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .start_last (last_slice_of(kind_in)),
    .busy       (busy),
    .slice      (fu_slice),
    .at_last    (fu_last)
  );

  wss_lane_gate #(.LANES(LANES), .MW(GRP_MAX), .SW(SW)) u_gate (
    .busy    (busy),
    .slice   (fu_slice),
    .mask    (mask_q),
    .lane_en (fu_lane_en)
  );

  assign fu_valid = busy;
  assign fu_token = token_q;
endmodule

// File: rtl/warp_slice_seq_chk.sv
module warp_slice_seq_chk #(
  parameter int LANES = 8,
  parameter int TOKW  = 16,
  parameter int SW    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             fu_valid,
  input logic [TOKW-1:0]  fu_token,
  input logic [SW-1:0]    fu_slice,
  input logic [LANES-1:0] fu_lane_en,
  input logic             fu_last,
  input logic             kind_vtx
);
  // R2: accepted request opens slice 0 next cycle
  p_accept_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (fu_valid && fu_slice == '0 && !in_ready));

  // R3 / R4: slices advance by one until the last
  p_slice_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fu_valid && !fu_last) |=> (fu_valid && fu_slice == SW'($past(fu_slice) + 1'b1)));

  // R4: vertex groups end on slice 1, fragment groups on slice 3
  p_last_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fu_last |-> (fu_slice == (kind_vtx ? SW'(1) : SW'(3))));

  // R6: token steady across a replay
  p_token_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fu_valid && !fu_last) |=> $stable(fu_token));

  // R8: no acceptance while replaying
  p_ready_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fu_valid |-> !in_ready);

  // R9: ready returns right after the final slice
  p_ready_after_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fu_last |=> (!fu_valid && in_ready));

  // R1 / R7: no lane is enabled outside an issue cycle
  p_idle_lanes_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !fu_valid |-> (fu_lane_en == '0));
endmodule

bind warp_slice_seq warp_slice_seq_chk #(.LANES(LANES), .TOKW(TOKW), .SW(SW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .fu_valid   (fu_valid),
  .fu_token   (fu_token),
  .fu_slice   (fu_slice),
  .fu_lane_en (fu_lane_en),
  .fu_last    (fu_last),
  .kind_vtx   (kind_q == warp_seq_pkg::GRP_VTX)
);

// File: tb/warp_slice_seq_test.sv
module warp_slice_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_token = '0;
  logic        in_group_vtx = 1'b0;
  logic [31:0] in_mask = '0;
  logic        fu_valid;
  logic [15:0] fu_token;
  logic [1:0]  fu_slice;
  logic [7:0]  fu_lane_en;
  logic        fu_last;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  warp_slice_seq uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_token(in_token), .in_group_vtx(in_group_vtx), .in_mask(in_mask),
    .fu_valid(fu_valid), .fu_token(fu_token), .fu_slice(fu_slice),
    .fu_lane_en(fu_lane_en), .fu_last(fu_last)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, cycles=%0d expected below 20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  // Issue one token and follow its replay slice by slice.
  // junk=1 keeps a different request on the inputs during the replay (R8, R11).
  task automatic run_instr(input logic [15:0] tok, input logic vtx,
                           input logic [31:0] mask, input logic junk);
    int n;
    n = vtx ? 2 : 4;
    @(negedge clk);
    check("R2 ready before accept", in_ready, 1);
    in_valid = 1'b1; in_token = tok; in_group_vtx = vtx; in_mask = mask;
    @(negedge clk);
    in_valid = junk; in_token = ~tok; in_group_vtx = ~vtx; in_mask = ~mask;
    for (int s = 0; s < n; s++) begin
      check("R2/R3/R4 valid", fu_valid, 1);
      check("R3/R4 slice index", fu_slice, s);
      check("R5/R7/R10 lane enables", fu_lane_en, (mask >> (s * 8)) & 32'hFF);
      check("R6/R11 token", fu_token, tok);
      check("R9 last flag", fu_last, (s == n - 1));
      check("R8 ready low", in_ready, 0);
      if (s < n - 1) @(negedge clk);
    end
    @(negedge clk);
    check("R9 idle after last", fu_valid, 0);
    check("R9 ready after last", in_ready, 1);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 ready", in_ready, 1);
    check("R1 valid", fu_valid, 0);
    check("R1 slice", fu_slice, 0);
    check("R1 last", fu_last, 0);
    check("R1 lanes", fu_lane_en, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_fragment();
    run_instr(16'hA001, 1'b0, 32'h8421_F00F, 1'b0);
    run_instr(16'hA002, 1'b0, 32'hFFFF_FFFF, 1'b0);
  endtask

  task automatic t_vertex();
    // R10: upper mask bits set but must not show
    run_instr(16'hB001, 1'b1, 32'hDEAD_3C81, 1'b0);
  endtask

  task automatic t_zero_slices();
    // R7: middle and final slices all-zero
    run_instr(16'hC001, 1'b0, 32'h0000_5A00, 1'b0);
    run_instr(16'hC002, 1'b1, 32'h0000_0000, 1'b0);
  endtask

  task automatic t_busy_request();
    // R8 / R11: a request held during replay is ignored, then taken once ready
    run_instr(16'hD001, 1'b0, 32'h1234_5678, 1'b1);
    in_valid = 1'b1; in_token = 16'hD002; in_group_vtx = 1'b1; in_mask = 32'h0000_00F0;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 held request taken", fu_token, 16'hD002);
    check("R8 held request slice0", fu_slice, 0);
    check("R8 held request lanes", fu_lane_en, 8'hF0);
    @(negedge clk);
    check("R4 held vertex last", fu_last, 1);
    @(negedge clk);
    check("R9 ready after held", in_ready, 1);
  endtask

  task automatic t_reset_midway();
    @(negedge clk);
    in_valid = 1'b1; in_token = 16'hE001; in_group_vtx = 1'b0; in_mask = '1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    t_reset();
  endtask

  initial begin
    t_reset();
    t_fragment();
    t_vertex();
    t_zero_slices();
    t_busy_request();
    t_reset_midway();
    run_instr(16'hF001, 1'b1, 32'hFFFF_0102, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule